// File: doc/BRIEF.md
# Time Base and Decrementer

This block keeps a 64-bit up-counting time base and a 32-bit down-counting decrementer. Both move by one on every cycle in which the shared tick enable is high. A clock divider outside the block produces the tick; the register decoder is also outside. Software writes either 32-bit half of the time base without disturbing the other half. It loads the decrementer with a full word. It reads the time base through a 64-bit snapshot that is captured in one cycle, so a carry from the low word into the high word cannot tear a read.

When the decrementer passes through zero, it continues from all-ones and raises a pending interrupt. A software load that turns the count from non-negative to negative (bit 31 going from clear to set) raises the interrupt at once. The pending flag is a two-state machine. In `IRQ_IDLE` the output is low, and the `RAISE` transition on a set event moves it to `IRQ_PEND`. In `IRQ_PEND` the output is high. `HOLD` keeps it there while no acknowledge arrives, and `CLEAR` returns it to `IRQ_IDLE` on an acknowledge in a cycle with no set event. The decrementer itself moves through three operations each cycle: `DEC_HOLD`, `DEC_COUNT` and `DEC_LOAD`.

A real-time-clock mode input restricts the low word of the time base to bits 29 down to 7 (mask 0x3FFFFF80), on writes and on reads. In that mode the tick enable is expected at 7.8125 MHz.

Top module: `tbdec_top`

## Requirements
- R1: After reset the time base is zero, the decrementer reads 0xFFFFFFFF, the snapshot reads zero and `dec_irq` is low.
- R2: The time base increases by exactly one at each clock edge where `tick_en` is high and no time base write is present. Without a tick it holds.
- R3: A write of the upper half (`wr_tbu`) loads bits 63..32 from `wr_data` and leaves bits 31..0 at their value before the write. The tick in that cycle is dropped.
- R4: A write of the lower half (`wr_tbl`) loads bits 31..0 and leaves bits 63..32 at their value before the write. The tick in that cycle is dropped.
- R5: A `snap` strobe at a clock edge copies the whole 64-bit time base, as it was before that edge, into the snapshot. `tbu_rd` shows snapshot bits 63..32 and `tbl_rd` shows bits 31..0, and both hold until the next strobe.
- R6: The decrementer decreases by exactly one at each clock edge with `tick_en` high and no load. Without a tick it holds.
- R7: A tick while the decrementer is 0 makes it 0xFFFFFFFF and sets `dec_irq` from the next cycle.
- R8: A load (`wr_dec`) of a value with bit 31 set, while the current count has bit 31 clear, sets `dec_irq` from the next cycle. A load of any other sign combination does not set it.
- R9: `dec_irq` stays high until an `ack` strobe in a cycle without a set event clears it. A set event in the same cycle as `ack` leaves it high.
- R10: With `rtc_mode` high, a lower-half write stores `wr_data & 0x3FFFFF80`, and `tbl_rd` shows the snapshot low word ANDed with 0x3FFFFF80.
- R11: A decrementer load takes priority over a tick in the same cycle. The count becomes exactly the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Time base and decrementer advance enable |
| rtc_mode | input | 1 | Real-time-clock mode: mask the low word with 0x3FFFFF80 |
| wr_tbu | input | 1 | Write strobe, time base upper half |
| wr_tbl | input | 1 | Write strobe, time base lower half |
| wr_dec | input | 1 | Load strobe, decrementer |
| wr_data | input | 32 | Write data for all three strobes |
| snap | input | 1 | Capture the time base into the read snapshot |
| ack | input | 1 | Clear the pending decrementer interrupt |
| tbu_rd | output | 32 | Snapshot upper word |
| tbl_rd | output | 32 | Snapshot lower word, masked in RTC mode |
| dec_rd | output | 32 | Current decrementer value |
| dec_irq | output | 1 | Decrementer interrupt pending |

## Verification
The bench goes after the carry from the low word into the high word. A design that read the halves at different times, or that let a half write also apply the tick, would return a torn or off-by-one time base.

It sweeps every pairing of old and new decrementer values across the sign boundary. This catches a design that raised the interrupt on any negative load, or missed the non-negative to negative case.

The expiry at zero is driven together with an acknowledge, so a design that let the acknowledge win would drop the interrupt. RTC mode is checked on both the write path and the read path; a mask applied on only one side leaks the low seven bits or the top two.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        DEC_HOLD  = 2'd0,
        DEC_COUNT = 2'd1,
        DEC_LOAD  = 2'd2
    } dec_op_e;

    typedef enum logic [1:0] {
        TB_HOLD  = 2'd0,
        TB_TICK  = 2'd1,
        TB_WRITE = 2'd2
    } tb_op_e;

endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
    parameter int          HALF_W  = 32,
    parameter logic [31:0] RTC_MSK = 32'h3FFF_FF80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  rtc_mode,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [HALF_W-1:0]     wr_data,
    input  logic                  snap,
    output logic [2*HALF_W-1:0]   tb_q,
    output logic [HALF_W-1:0]     snap_hi,
    output logic [HALF_W-1:0]     snap_lo
);
    import tbdec_pkg::*;

    localparam int TB_W = 2 * HALF_W;

    logic [TB_W-1:0]   snap_q;
    logic [HALF_W-1:0] lo_mask;
    tb_op_e            op;

    assign lo_mask = rtc_mode ? RTC_MSK[HALF_W-1:0] : {HALF_W{1'b1}};

    always_comb begin
        if (wr_hi || wr_lo) begin
            op = TB_WRITE;
        end else if (tick_en) begin
            op = TB_TICK;
        end else begin
            op = TB_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            unique case (op)
                TB_WRITE: begin
                    if (wr_hi) tb_q[TB_W-1:HALF_W] <= wr_data;
                    if (wr_lo) tb_q[HALF_W-1:0]    <= wr_data & lo_mask;
                end
                TB_TICK:  tb_q <= tb_q + TB_W'(1);
                default:  tb_q <= tb_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap) begin
            snap_q <= tb_q;
        end
    end

    assign snap_hi = snap_q[TB_W-1:HALF_W];
    assign snap_lo = snap_q[HALF_W-1:0] & lo_mask;

endmodule

// File: rtl/tbdec_decr.sv
module tbdec_decr #(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [DEC_W-1:0] wr_data,
    output logic [DEC_W-1:0] dec_q,
    output logic             set_evt
);
    import tbdec_pkg::*;

    localparam int MSB = DEC_W - 1;

    dec_op_e op;
    logic    expire;
    logic    neg_load;

    always_comb begin
        if (wr_en) begin
            op = DEC_LOAD;
        end else if (tick_en) begin
            op = DEC_COUNT;
        end else begin
            op = DEC_HOLD;
        end
    end

    assign expire   = (op == DEC_COUNT) && (dec_q == '0);
    assign neg_load = (op == DEC_LOAD) && wr_data[MSB] && !dec_q[MSB];
    assign set_evt  = expire || neg_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '1;
        end else begin
            unique case (op)
                DEC_LOAD:  dec_q <= wr_data;
                DEC_COUNT: dec_q <= dec_q - DEC_W'(1);
                default:   dec_q <= dec_q;
            endcase
        end
    end

endmodule

// File: rtl/tbdec_irq_fsm.sv
module tbdec_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic ack,
    output logic irq
);
    import tbdec_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (set_evt) state_d = IRQ_PEND;
            IRQ_PEND: if (ack && !set_evt) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end

endmodule

// File: rtl/tbdec_top.sv
module tbdec_top #(
    parameter int          WORD_W  = 32,
    parameter logic [31:0] RTC_MSK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rtc_mode,
    input  logic              wr_tbu,
    input  logic              wr_tbl,
    input  logic              wr_dec,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              snap,
    input  logic              ack,
    output logic [WORD_W-1:0] tbu_rd,
    output logic [WORD_W-1:0] tbl_rd,
    output logic [WORD_W-1:0] dec_rd,
    output logic              dec_irq
);
    localparam int TB_W = 2 * WORD_W;

    logic [TB_W-1:0] tb_q;
    logic            set_evt;

    tbdec_timebase #(
        .HALF_W  (WORD_W),
        .RTC_MSK (RTC_MSK)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .rtc_mode (rtc_mode),
        .wr_hi    (wr_tbu),
        .wr_lo    (wr_tbl),
        .wr_data  (wr_data),
        .snap     (snap),
        .tb_q     (tb_q),
        .snap_hi  (tbu_rd),
        .snap_lo  (tbl_rd)
    );

    tbdec_decr #(
        .DEC_W (WORD_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_dec),
        .wr_data (wr_data),
        .dec_q   (dec_rd),
        .set_evt (set_evt)
    );

    tbdec_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .ack     (ack),
        .irq     (dec_irq)
    );

endmodule

// File: rtl/tbdec_chk.sv
module tbdec_chk #(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                wr_tbu,
    input logic                wr_tbl,
    input logic                wr_dec,
    input logic [WORD_W-1:0]   wr_data,
    input logic                snap,
    input logic                ack,
    input logic [2*WORD_W-1:0] tb_q,
    input logic [WORD_W-1:0]   tbu_rd,
    input logic [WORD_W-1:0]   dec_rd,
    input logic                dec_irq
);
    localparam int TB_W = 2 * WORD_W;
    localparam int MSB  = WORD_W - 1;

    p_tb_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_tbu && !wr_tbl) |=> (tb_q == $past(tb_q) + TB_W'(1)));

    p_lo_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tbu && !wr_tbl) |=> (tb_q[WORD_W-1:0] == $past(tb_q[WORD_W-1:0])));

    p_hi_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tbl && !wr_tbu) |=> (tb_q[TB_W-1:WORD_W] == $past(tb_q[TB_W-1:WORD_W])));

    p_snap_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (tbu_rd == $past(tb_q[TB_W-1:WORD_W])));

    p_dec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_dec) |=> (dec_rd == $past(dec_rd) - WORD_W'(1)));

    p_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_dec && dec_rd == '0) |=> (dec_irq && dec_rd == '1));

    p_neg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dec && wr_data[MSB] && !dec_rd[MSB]) |=> dec_irq);

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_irq && !ack) |=> dec_irq);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_irq && ack && !tick_en && !wr_dec) |=> !dec_irq);

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dec |=> (dec_rd == $past(wr_data)));

endmodule

bind tbdec_top tbdec_chk #(
    .WORD_W (WORD_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_tbu  (wr_tbu),
    .wr_tbl  (wr_tbl),
    .wr_dec  (wr_dec),
    .wr_data (wr_data),
    .snap    (snap),
    .ack     (ack),
    .tb_q    (tb_q),
    .tbu_rd  (tbu_rd),
    .dec_rd  (dec_rd),
    .dec_irq (dec_irq)
);

// File: tb/tbdec_top_tb_top.sv
module tbdec_top_tb_top;

    localparam logic [31:0] MSK = 32'h3FFF_FF80;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, rtc_mode, wr_tbu, wr_tbl, wr_dec, snap, ack;
    logic [31:0] wr_data;
    logic [31:0] tbu_rd, tbl_rd, dec_rd;
    logic        dec_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [63:0] m_tb, m_snap;
    logic [31:0] m_dec;
    logic        m_irq;

    always #10 clk = ~clk;

    tbdec_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .rtc_mode (rtc_mode),
        .wr_tbu   (wr_tbu),
        .wr_tbl   (wr_tbl),
        .wr_dec   (wr_dec),
        .wr_data  (wr_data),
        .snap     (snap),
        .ack      (ack),
        .tbu_rd   (tbu_rd),
        .tbl_rd   (tbl_rd),
        .dec_rd   (dec_rd),
        .dec_irq  (dec_irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lmask();
        return rtc_mode ? MSK : 32'hFFFF_FFFF;
    endfunction

    task automatic step(input logic t, input logic wtu, input logic wtl,
                        input logic wd, input logic sn, input logic ak,
                        input logic [31:0] d, input string tag);
        logic set;
        tick_en = t; wr_tbu = wtu; wr_tbl = wtl; wr_dec = wd;
        snap = sn; ack = ak; wr_data = d;
        @(posedge clk);
        if (sn) m_snap = m_tb;
        if (wtu || wtl) begin
            if (wtu) m_tb[63:32] = d;
            if (wtl) m_tb[31:0]  = d & lmask();
        end else if (t) begin
            m_tb = m_tb + 64'd1;
        end
        set = (wd && d[31] && !m_dec[31]) || (!wd && t && m_dec == 32'd0);
        if (wd) m_dec = d;
        else if (t) m_dec = m_dec - 32'd1;
        if (set) m_irq = 1'b1;
        else if (ak) m_irq = 1'b0;
        @(negedge clk);
        tick_en = 0; wr_tbu = 0; wr_tbl = 0; wr_dec = 0; snap = 0; ack = 0;
        chk(tag, "dec_rd", {32'd0, dec_rd}, {32'd0, m_dec});
        chk(tag, "dec_irq", {63'd0, dec_irq}, {63'd0, m_irq});
        if (sn) begin
            chk(tag, "tbu_rd", {32'd0, tbu_rd}, {32'd0, m_snap[63:32]});
            chk(tag, "tbl_rd", {32'd0, tbl_rd}, {32'd0, m_snap[31:0] & lmask()});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [5];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF;
        rst_n = 0; tick_en = 0; rtc_mode = 0; wr_tbu = 0; wr_tbl = 0;
        wr_dec = 0; snap = 0; ack = 0; wr_data = '0;
        m_tb = '0; m_snap = '0; m_dec = 32'hFFFF_FFFF; m_irq = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "dec_rd", {32'd0, dec_rd}, 64'hFFFF_FFFF);
        chk("R1", "dec_irq", {63'd0, dec_irq}, 64'd0);
        chk("R1", "tbu_rd", {32'd0, tbu_rd}, 64'd0);
        chk("R1", "tbl_rd", {32'd0, tbl_rd}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        step(0, 0, 0, 0, 1, 0, 32'd0, "R1");

        // R2, R6: ticking with gaps
        for (int i = 0; i < 24; i++) step((i % 3) != 2, 0, 0, 0, 1, 0, 32'd0, "R2_R6");

        // R4 then R3: half writes with ticks present, then carry (R5)
        step(1, 0, 1, 0, 0, 0, 32'hFFFF_FFF8, "R4");
        step(1, 0, 0, 0, 1, 0, 32'd0, "R4");
        step(1, 1, 0, 0, 0, 0, 32'h0000_0007, "R3");
        step(0, 0, 0, 0, 1, 0, 32'd0, "R3");
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 1, 0, 32'd0, "R5");
        step(0, 0, 0, 0, 0, 0, 32'd0, "R5");
        chk("R5", "tbu_hold", {32'd0, tbu_rd}, {32'd0, m_snap[63:32]});

        // R7: expiry at zero
        step(0, 0, 0, 1, 0, 0, 32'd3, "R8");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, 32'd0, "R7");
        // R9: hold, then clear
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 32'd0, "R9");
        step(0, 0, 0, 0, 0, 1, 32'd0, "R9");
        // R9: expiry wins over acknowledge
        step(0, 0, 0, 1, 0, 0, 32'd0, "R9");
        step(1, 0, 0, 0, 0, 1, 32'd0, "R9");
        step(0, 0, 0, 0, 0, 1, 32'd0, "R9");

        // R8: sign sweep over every old/new pair
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                step(0, 0, 0, 1, 0, 0, vals[a], "R8");
                step(0, 0, 0, 0, 0, 1, 32'd0, "R8");
                step(0, 0, 0, 1, 0, 0, vals[b], "R8");
            end
        end

        // R11: load together with tick
        step(0, 0, 0, 0, 0, 1, 32'd0, "R11");
        step(1, 0, 0, 1, 0, 0, 32'h0000_1234, "R11");
        step(1, 0, 0, 1, 0, 0, 32'h0000_0000, "R11");

        // R10: RTC mask on write and read
        rtc_mode = 1;
        step(0, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, "R10");
        step(0, 0, 0, 0, 1, 0, 32'd0, "R10");
        for (int i = 0; i < 140; i++) step(1, 0, 0, 0, (i % 20) == 0, 0, 32'd0, "R10");
        step(0, 0, 1, 0, 0, 0, 32'h1234_5678, "R10");
        step(0, 0, 0, 0, 1, 0, 32'd0, "R10");
        rtc_mode = 0;
        #1;
        chk("R10", "tbl_unmasked", {32'd0, tbl_rd}, {32'd0, m_snap[31:0]});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule